// File: doc/BRIEF.md
# Supply On/Off and Fault Latch Controller

This block drives the shutdown line of a power-supply output supervisor. It takes an active-low remote on/off request and, for each output rail, an overvoltage and an undervoltage flag that earlier comparators have already turned into logic levels. A system clock, an asynchronous power-on reset and a single-cycle timebase tick clock its timers. Every delay is a parameter counted in ticks.

The request must hold a new level for a full debounce window before it is accepted. Turning on takes effect one clock after acceptance. Turning off adds a further drain delay before the shutdown line rises. A comparator flag counts as a fault only after it has stayed high for a glitch window. Undervoltage is ignored for a blanking window after every enable, while overvoltage is never ignored. A fault forces shutdown at once and stays latched until the accepted request moves from on to off, or until reset. A registered inhibit output tells the power-good logic to hold its signal low whenever the rails are off.

The control and status pins are plain levels with no handshake.

Top module: `sup_onoff_fault_ctrl`

## Requirements
- R1: After reset, `shutdown` is 1, `pg_inhibit` is 1 and `fault_latched` is 0.
- R2: `req_off_n` = 0 requests on. Suppose it is held low from the off state with no fault latched and `tick` high every cycle. Then `shutdown` falls DEBOUNCE_TICKS+1 clocks after the change.
- R3: If the request returns to its accepted level before DEBOUNCE_TICKS ticks have passed, nothing changes, and the debounce count starts again from zero.
- R4: If the request goes high while the rails are on, `shutdown` rises DEBOUNCE_TICKS+1+DRAIN_TICKS clocks after the change.
- R5: A flag that stays high for fewer than GLITCH_TICKS consecutive ticks never causes a fault. The count restarts whenever the flag drops.
- R6: If any bit of `ov_flag` (bit i is rail i) stays high, `shutdown` and `fault_latched` rise GLITCH_TICKS+1 clocks later. This holds inside the blanking window too.
- R7: An undervoltage flag on any rail is ignored for BLANK_TICKS ticks after `shutdown` falls. A flag that is already qualified trips the block BLANK_TICKS+1 clocks after the fall. After the window, a raised `uv_flag` bit trips the block GLITCH_TICKS+1 clocks later.
- R8: A latched fault holds `shutdown` high even after the flag clears and while the request stays on. It clears DEBOUNCE_TICKS+1 clocks after the request goes high. After that, a new on request turns the rails on again.
- R9: `pg_inhibit` is 1 whenever `shutdown` is 1, and 0 while the rails are on.
- R10: Timers advance only in cycles where `tick` is 1. With `tick` held low, a request change has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Timebase strobe; every timer advances by one per cycle it is high |
| req_off_n | input | 1 | Remote request, 0 = rails on, 1 = rails off |
| ov_flag | input | NUM_RAILS | Overvoltage comparator flags, bit i for rail i |
| uv_flag | input | NUM_RAILS | Undervoltage comparator flags, bit i for rail i |
| shutdown | output | 1 | 1 = rails held off |
| pg_inhibit | output | 1 | 1 = power-good output must be held low |
| fault_latched | output | 1 | Fault latch state, for test |

## Verification
The request is driven in four ways:
- a bounce shorter than the debounce window, which separates a restarting counter from an accumulating one;
- a change with the tick gated off, which shows that counting follows the tick and not the clock;
- clean on and off steps, which show the asymmetric turn-on and turn-off delays;
- an off step while a fault is held, which must clear the latch.

The comparator flags are driven in three ways:
- a pulse one tick too short, and two such pulses one cycle apart, which separate a restarting filter from an accumulating one;
- a held overvoltage flag inside the blanking window, which must trip;
- a held undervoltage flag, both across the blanking window and after it, which shows the mask lasts exactly the window and lifts after it.

// File: rtl/sup_ctrl_pkg.sv
package sup_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ON    = 2'd1,
    ST_DRAIN = 2'd2
  } sup_state_e;
endpackage

// File: rtl/sup_req_debounce.sv
module sup_req_debounce #(
  parameter int DEBOUNCE_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req_off_n,
  output logic req_on
);
  localparam int CW = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_TICKS - 1);

  logic          raw_on;
  logic [CW-1:0] cnt_q;

  assign raw_on = ~req_off_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      req_on <= 1'b0;
    end else if (raw_on == req_on) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        req_on <= raw_on;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3
  accept_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_on != $past(req_on)) |-> (req_on == $past(raw_on)));
  // R10
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(req_on));
endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
  parameter int GLITCH_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag,
  output logic qual
);
  localparam int CW = $clog2(GLITCH_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      qual  <= 1'b0;
    end else if (!flag) begin
      cnt_q <= '0;
      qual  <= 1'b0;
    end else if (tick && !qual) begin
      if (cnt_q == LAST) qual  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  qual_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qual) |-> ($past(flag) && $past(tick)));
  // R5
  qual_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |=> !qual);
endmodule

// File: rtl/sup_seq_ctrl.sv
module sup_seq_ctrl
  import sup_ctrl_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int DRAIN_TICKS = 3,
  parameter int BLANK_TICKS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 req_on,
  input  logic [NUM_RAILS-1:0] ov_q,
  input  logic [NUM_RAILS-1:0] uv_q,
  output logic                 shutdown_q,
  output logic                 pg_inh_q,
  output logic                 fault_q
);
  localparam int DW = $clog2(DRAIN_TICKS + 1);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam logic [DW-1:0] DRAIN_LAST = DW'(DRAIN_TICKS - 1);
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_TICKS);

  sup_state_e    state_q, state_d;
  logic [DW-1:0] drain_q, drain_d;
  logic [BW-1:0] blank_q, blank_d;
  logic          req_on_d1;
  logic          shutdown_d, fault_d;
  logic          blanking, uv_live, trip, clr;

  assign blanking = (blank_q != '0);
  assign uv_live  = (state_q == ST_ON) && !blanking && (|uv_q);
  assign trip     = (|ov_q) || uv_live;
  assign clr      = req_on_d1 && !req_on;

  always_comb begin
    state_d    = state_q;
    drain_d    = drain_q;
    shutdown_d = shutdown_q;
    fault_d    = clr ? 1'b0 : (fault_q | trip);
    blank_d    = (tick && blanking) ? blank_q - 1'b1 : blank_q;
    unique case (state_q)
      ST_OFF: begin
        if (req_on && !fault_q && !trip) begin
          state_d    = ST_ON;
          shutdown_d = 1'b0;
          blank_d    = BLANK_LOAD;
        end
      end
      ST_ON: begin
        if (trip) begin
          state_d    = ST_OFF;
          shutdown_d = 1'b1;
        end else if (!req_on) begin
          state_d = ST_DRAIN;
          drain_d = '0;
        end
      end
      ST_DRAIN: begin
        if (trip) begin
          state_d    = ST_OFF;
          shutdown_d = 1'b1;
        end else if (req_on) begin
          state_d = ST_ON;
        end else if (tick) begin
          if (drain_q == DRAIN_LAST) begin
            state_d    = ST_OFF;
            shutdown_d = 1'b1;
          end else begin
            drain_d = drain_q + 1'b1;
          end
        end
      end
      default: begin
        state_d    = ST_OFF;
        shutdown_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OFF;
      drain_q    <= '0;
      blank_q    <= '0;
      req_on_d1  <= 1'b0;
      shutdown_q <= 1'b1;
      pg_inh_q   <= 1'b1;
      fault_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      drain_q    <= drain_d;
      blank_q    <= blank_d;
      req_on_d1  <= req_on;
      shutdown_q <= shutdown_d;
      pg_inh_q   <= shutdown_d;
      fault_q    <= fault_d;
    end
  end

  // R6
  fault_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> shutdown_q);
  // R9
  pg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_q |-> pg_inh_q);
  // R7
  uv_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> ($past(|ov_q) || ($past(|uv_q) && ($past(blank_q) == '0))));
  // R8
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> ($past(req_on_d1) && !$past(req_on)));
  // R2
  on_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown_q) |-> ($past(req_on) && !$past(fault_q)));
endmodule

// File: rtl/sup_onoff_fault_ctrl.sv
module sup_onoff_fault_ctrl #(
  parameter int NUM_RAILS      = 3,
  parameter int DEBOUNCE_TICKS = 8,
  parameter int DRAIN_TICKS    = 3,
  parameter int GLITCH_TICKS   = 4,
  parameter int BLANK_TICKS    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 req_off_n,
  input  logic [NUM_RAILS-1:0] ov_flag,
  input  logic [NUM_RAILS-1:0] uv_flag,
  output logic                 shutdown,
  output logic                 pg_inhibit,
  output logic                 fault_latched
);
  logic                 req_on;
  logic [NUM_RAILS-1:0] ov_q, uv_q;

  sup_req_debounce #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) i_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_off_n(req_off_n), .req_on(req_on)
  );

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    sup_glitch_filter #(.GLITCH_TICKS(GLITCH_TICKS)) i_ov (
      .clk(clk), .rst_n(rst_n), .tick(tick), .flag(ov_flag[g]), .qual(ov_q[g])
    );
    sup_glitch_filter #(.GLITCH_TICKS(GLITCH_TICKS)) i_uv (
      .clk(clk), .rst_n(rst_n), .tick(tick), .flag(uv_flag[g]), .qual(uv_q[g])
    );
  end

  sup_seq_ctrl #(
    .NUM_RAILS(NUM_RAILS), .DRAIN_TICKS(DRAIN_TICKS), .BLANK_TICKS(BLANK_TICKS)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_on(req_on),
    .ov_q(ov_q), .uv_q(uv_q),
    .shutdown_q(shutdown), .pg_inh_q(pg_inhibit), .fault_q(fault_latched)
  );

  // R1
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |=> (shutdown && pg_inhibit && !fault_latched));
endmodule

// File: tb/test_sup_onoff_fault_ctrl.sv
module test_sup_onoff_fault_ctrl;
  localparam int NR  = 3;
  localparam int DEB = 8;
  localparam int DRN = 3;
  localparam int GL  = 4;
  localparam int BLK = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b1;
  logic          req_off_n = 1'b1;
  logic [NR-1:0] ov_flag = '0;
  logic [NR-1:0] uv_flag = '0;
  logic          shutdown, pg_inhibit, fault_latched;
  int            checks = 0;
  int            errors = 0;

  always #4 clk = ~clk;

  sup_onoff_fault_ctrl #(
    .NUM_RAILS(NR), .DEBOUNCE_TICKS(DEB), .DRAIN_TICKS(DRN),
    .GLITCH_TICKS(GL), .BLANK_TICKS(BLK)
  ) i_sup_onoff_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .req_off_n(req_off_n),
    .ov_flag(ov_flag), .uv_flag(uv_flag),
    .shutdown(shutdown), .pg_inhibit(pg_inhibit), .fault_latched(fault_latched)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_sd(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (shutdown !== lvl && n < 2000);
  endtask

  task automatic wait_fault(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (fault_latched !== lvl && n < 2000);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic t_reset;
    idle(1);
    chk(shutdown === 1'b1, "R1 shutdown", shutdown, 1);
    chk(pg_inhibit === 1'b1, "R1 pg_inhibit", pg_inhibit, 1);
    chk(fault_latched === 1'b0, "R1 fault_latched", fault_latched, 0);
  endtask

  task automatic t_bounce;
    req_off_n = 1'b0; idle(DEB - 1);
    req_off_n = 1'b1; idle(1);
    req_off_n = 1'b0; idle(DEB - 1);
    req_off_n = 1'b1; idle(3 * DEB);
    chk(shutdown === 1'b1, "R3 bounce ignored", shutdown, 1);
  endtask

  task automatic t_tick_gate;
    int n;
    tick_en = 1'b0;
    req_off_n = 1'b0;
    idle(4 * DEB);
    chk(shutdown === 1'b1, "R10 no tick no change", shutdown, 1);
    tick_en = 1'b1;
    wait_sd(1'b0, n);
    chk(n == DEB + 1, "R2 turn-on delay", n, DEB + 1);
    chk(pg_inhibit === 1'b0, "R9 pg released when on", pg_inhibit, 0);
  endtask

  task automatic t_glitch;
    idle(BLK + 5);
    ov_flag[1] = 1'b1; idle(GL - 1);
    ov_flag[1] = 1'b0; idle(10);
    chk(shutdown === 1'b0, "R5 short pulse", shutdown, 0);
    uv_flag[0] = 1'b1; idle(GL - 1);
    uv_flag[0] = 1'b0; idle(1);
    uv_flag[0] = 1'b1; idle(GL - 1);
    uv_flag[0] = 1'b0; idle(10);
    chk(shutdown === 1'b0, "R5 split pulses", shutdown, 0);
    chk(fault_latched === 1'b0, "R5 no latch", fault_latched, 0);
  endtask

  task automatic t_turn_off;
    int n;
    req_off_n = 1'b1;
    wait_sd(1'b1, n);
    chk(n == DEB + 1 + DRN, "R4 turn-off delay", n, DEB + 1 + DRN);
    chk(pg_inhibit === 1'b1, "R9 pg forced with shutdown", pg_inhibit, 1);
    chk(fault_latched === 1'b0, "R4 clean off", fault_latched, 0);
    idle(4);
  endtask

  task automatic t_ov_latch;
    int n;
    req_off_n = 1'b0;
    wait_sd(1'b0, n);
    chk(n == DEB + 1, "R2 turn-on again", n, DEB + 1);
    ov_flag[2] = 1'b1;
    wait_sd(1'b1, n);
    chk(n == GL + 1, "R6 ov trip inside blanking", n, GL + 1);
    chk(fault_latched === 1'b1, "R6 latched", fault_latched, 1);
    ov_flag[2] = 1'b0;
    idle(30);
    chk(shutdown === 1'b1, "R8 hold after flag clears", shutdown, 1);
    chk(fault_latched === 1'b1, "R8 latch holds", fault_latched, 1);
    req_off_n = 1'b1;
    wait_fault(1'b0, n);
    chk(n == DEB + 1, "R8 clear delay", n, DEB + 1);
    chk(shutdown === 1'b1, "R8 off while clearing", shutdown, 1);
    idle(4);
    req_off_n = 1'b0;
    wait_sd(1'b0, n);
    chk(n == DEB + 1, "R8 restart after clear", n, DEB + 1);
    idle(BLK + 2);
    req_off_n = 1'b1;
    wait_sd(1'b1, n);
    idle(4);
  endtask

  task automatic t_uv;
    int n;
    uv_flag[0] = 1'b1;
    idle(GL + 2);
    req_off_n = 1'b0;
    wait_sd(1'b0, n);
    chk(n == DEB + 1, "R7 on with uv present", n, DEB + 1);
    wait_sd(1'b1, n);
    chk(n == BLK + 1, "R7 blank window", n, BLK + 1);
    chk(fault_latched === 1'b1, "R7 uv latched", fault_latched, 1);
    uv_flag[0] = 1'b0;
    req_off_n = 1'b1;
    wait_fault(1'b0, n);
    idle(4);
    req_off_n = 1'b0;
    wait_sd(1'b0, n);
    idle(BLK + 3);
    uv_flag[2] = 1'b1;
    wait_sd(1'b1, n);
    chk(n == GL + 1, "R7 uv after window", n, GL + 1);
    uv_flag[2] = 1'b0;
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    t_reset();
    t_bounce();
    t_tick_gate();
    t_glitch();
    t_turn_off();
    t_ov_latch();
    t_uv();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule